// File: doc/BRIEF.md
# Command Stream Register Writer

This block turns a flat list of 32-bit words into register writes. A list begins with a one-cycle `list_start` pulse. The pulse carries the list size in bytes. The words then arrive one at a time on a valid/ready input.

The words are grouped into packets:

- Each packet carries its first payload word ahead of the header word.
- The header names a target register, a byte-lane enable mask, a count of further payload words and a group bit.
- When the group bit is set, the further payload words go to ascending registers. When it is clear, they all go to the same register.
- Packets always begin at an even word offset from the list's first word, so a filler word is skipped where needed.

Every accepted write appears on a registered output port with its register number, data and lane mask. The same write is merged into a local register file: enabled byte lanes are replaced and disabled lanes keep their old contents. That file can be read back combinationally. A write aimed past the end of the register file is suppressed. A sticky error flag records the first such target.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `in_ready`, `wr_valid` and `err_flag` are 0, and every register file entry reads 0.
- R2: A packet is a payload word followed by a header word. Accepting the header issues one write of that payload word to the header's register, visible on the `wr_*` port in the cycle after the accepting clock edge.
- R3: Header fields are: register number in bits [15:0], lane mask in bits [19:16], extra-word count in bits [27:20], group bit in bit 31. Bits [30:28] are ignored.
- R4: With the group bit at 1, the i-th extra word (i counting from 1) is written to register number + i.
- R5: With the group bit at 0, every extra word is written to the header's register number.
- R6: Every write of a packet carries that packet's mask on `wr_mask`. In the register file, mask bit k selects byte k (bits 8k+7..8k); a clear bit leaves that byte unchanged.
- R7: When a packet would start at an odd word offset counted from the list's first word, that word is consumed as filler and causes no write.
- R8: A write whose target is 768 or above produces no `wr_valid` and no register file change. It sets `err_flag`, which stays set until reset. `err_id` holds the first such target.
- R9: The list holds `list_bytes`/4 words, rounded down. Once that many words are accepted, `in_ready` falls and no further words are taken; a list size of 0 leaves `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_start | input | 1 | Begins a new list, word offset set to 0 |
| list_bytes | input | 16 | List size in bytes, sampled with `list_start` |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts a word this cycle |
| wr_valid | output | 1 | Register write issued |
| wr_id | output | 16 | Target register of the write |
| wr_data | output | 32 | Write data |
| wr_mask | output | 4 | Byte-lane enables of the write |
| err_flag | output | 1 | Sticky out-of-range target flag |
| err_id | output | 16 | First out-of-range target |
| rd_id | input | 16 | Register file read address |
| rd_data | output | 32 | Register file contents at `rd_id` (0 when out of range) |

## Verification
Single-packet lists are replayed against one register with the masks full, alternating lanes, the complementary lanes and empty. This separates true lane merging from plain overwrite or ignored masks. Lists with two extra words are sent once with the group bit set and once clear, which tells ascending targets apart from repeated ones. A list whose first packet has an odd word count shows whether the filler word is skipped rather than parsed as a payload word. Out-of-range targets are sent both directly and by a grouped packet that crosses the top entry. Lists that end exactly, or that have zero length, expose whether the block stops consuming words.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

    localparam int DATA_W = 32;
    localparam int ID_W   = 16;
    localparam int MASK_W = 4;
    localparam int XCNT_W = 8;

    // header field positions
    localparam int HID_LSB   = 0;
    localparam int HMASK_LSB = 16;
    localparam int HCNT_LSB  = 20;
    localparam int HGRP_BIT  = 31;

    typedef struct packed {
        logic              grp;
        logic [XCNT_W-1:0] xcnt;
        logic [MASK_W-1:0] mask;
        logic [ID_W-1:0]   id;
    } hdr_t;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_DATA  = 2'd1,
        PS_HDR   = 2'd2,
        PS_EXTRA = 2'd3
    } pstate_t;

    // write request; id is one bit wider so a grouped sum cannot wrap
    typedef struct packed {
        logic              vld;
        logic [ID_W:0]     id;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
    } wreq_t;

    function automatic hdr_t hdr_decode(input logic [DATA_W-1:0] w);
        hdr_t h;
        h.id   = w[HID_LSB +: ID_W];
        h.mask = w[HMASK_LSB +: MASK_W];
        h.xcnt = w[HCNT_LSB +: XCNT_W];
        h.grp  = w[HGRP_BIT];
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] lane_expand(input logic [MASK_W-1:0] m);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < MASK_W; k++) begin
            r[8*k +: 8] = {8{m[k]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              list_start,
    input  logic [LEN_W-1:0]  list_bytes,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output wreq_t             req
);

    localparam int PW = LEN_W - 2;

    pstate_t           st;
    logic [PW-1:0]     pos;
    logic [PW-1:0]     len_w;
    logic [DATA_W-1:0] data_buf;
    hdr_t              cur;
    logic [XCNT_W-1:0] idx;
    logic [XCNT_W-1:0] left;
    hdr_t              hin;
    logic              accept;

    assign in_ready = (st != PS_IDLE);
    assign accept   = in_valid && in_ready;
    assign hin      = hdr_decode(in_data);

    always_comb begin
        req = '0;
        if (accept) begin
            case (st)
                PS_HDR: begin
                    req.vld  = 1'b1;
                    req.id   = {1'b0, hin.id};
                    req.data = data_buf;
                    req.mask = hin.mask;
                end
                PS_EXTRA: begin
                    req.vld  = 1'b1;
                    req.id   = cur.grp ? ({1'b0, cur.id} + (ID_W+1)'(idx)) : {1'b0, cur.id};
                    req.data = in_data;
                    req.mask = cur.mask;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_IDLE;
            pos      <= '0;
            len_w    <= '0;
            data_buf <= '0;
            cur      <= '0;
            idx      <= '0;
            left     <= '0;
        end else if (list_start) begin
            len_w <= list_bytes[LEN_W-1:2];
            pos   <= '0;
            st    <= (list_bytes[LEN_W-1:2] == '0) ? PS_IDLE : PS_DATA;
        end else if (accept) begin
            pos <= pos + 1'b1;
            case (st)
                PS_DATA: begin
                    if (!pos[0]) begin
                        data_buf <= in_data;
                        st       <= PS_HDR;
                    end
                end
                PS_HDR: begin
                    cur  <= hin;
                    idx  <= XCNT_W'(1);
                    left <= hin.xcnt;
                    st   <= (hin.xcnt != '0) ? PS_EXTRA : PS_DATA;
                end
                PS_EXTRA: begin
                    idx  <= idx + 1'b1;
                    left <= left - 1'b1;
                    if (left == XCNT_W'(1)) st <= PS_DATA;
                end
                default: ;
            endcase
            if (pos + 1'b1 == len_w) st <= PS_IDLE;
        end
    end

    // R9
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st != PS_IDLE) |-> (pos < len_w));

    // R4
    extra_left_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PS_EXTRA) |-> (left != '0));

    // R7
    pad_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !list_start && st == PS_DATA && pos[0]) |=> (st != PS_HDR));

endmodule

// File: rtl/cmd_wstage.sv
module cmd_wstage
    import cmd_pkg::*;
#(
    parameter int NREG = 768
) (
    input  logic              clk,
    input  logic              rst,
    input  wreq_t             req,
    output logic              rf_we,
    output logic [ID_W-1:0]   rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic [MASK_W-1:0] rf_mask,
    output logic              wr_valid,
    output logic [ID_W-1:0]   wr_id,
    output logic [DATA_W-1:0] wr_data,
    output logic [MASK_W-1:0] wr_mask,
    output logic              err_flag,
    output logic [ID_W-1:0]   err_id
);

    logic in_range;

    assign in_range = (req.id < (ID_W+1)'(NREG));
    assign rf_we    = req.vld && in_range;
    assign rf_addr  = req.id[ID_W-1:0];
    assign rf_data  = req.data;
    assign rf_mask  = req.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_id    <= '0;
            wr_data  <= '0;
            wr_mask  <= '0;
            err_flag <= 1'b0;
            err_id   <= '0;
        end else begin
            wr_valid <= rf_we;
            if (rf_we) begin
                wr_id   <= req.id[ID_W-1:0];
                wr_data <= req.data;
                wr_mask <= req.mask;
            end
            if (req.vld && !in_range && !err_flag) begin
                err_flag <= 1'b1;
                err_id   <= (req.id[ID_W] != 1'b0) ? {ID_W{1'b1}} : req.id[ID_W-1:0];
            end
        end
    end

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_id < ID_W'(NREG)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> $stable(err_id));

endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
    import cmd_pkg::*;
#(
    parameter int NREG = 768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ID_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MASK_W-1:0] wmask,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(NREG);

    logic [DATA_W-1:0] mem [NREG];
    logic [DATA_W-1:0] lanes;

    assign lanes = lane_expand(wmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr[IDX_W-1:0]] <= (mem[waddr[IDX_W-1:0]] & ~lanes) | (wdata & lanes);
        end
    end

    assign rd_data = (rd_id < ID_W'(NREG)) ? mem[rd_id[IDX_W-1:0]] : '0;

    // R6
    keep_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wmask == '0 && rd_id == waddr) ##1 $stable(rd_id) |-> $stable(rd_data));

    // R8
    we_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr < ID_W'(NREG)));

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int NREG  = 768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              list_start,
    input  logic [LEN_W-1:0]  list_bytes,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [ID_W-1:0]   wr_id,
    output logic [DATA_W-1:0] wr_data,
    output logic [MASK_W-1:0] wr_mask,
    output logic              err_flag,
    output logic [ID_W-1:0]   err_id,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data
);

    wreq_t             req;
    logic              rf_we;
    logic [ID_W-1:0]   rf_addr;
    logic [DATA_W-1:0] rf_data;
    logic [MASK_W-1:0] rf_mask;

    cmd_parser #(.LEN_W(LEN_W)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .list_start (list_start),
        .list_bytes (list_bytes),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .req        (req)
    );

    cmd_wstage #(.NREG(NREG)) u_wstage (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_data  (rf_data),
        .rf_mask  (rf_mask),
        .wr_valid (wr_valid),
        .wr_id    (wr_id),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .err_flag (err_flag),
        .err_id   (err_id)
    );

    cmd_regfile #(.NREG(NREG)) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_addr),
        .wdata   (rf_data),
        .wmask   (rf_mask),
        .rd_id   (rd_id),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        list_start;
    logic [15:0] list_bytes;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        wr_valid;
    logic [15:0] wr_id;
    logic [31:0] wr_data;
    logic [3:0]  wr_mask;
    logic        err_flag;
    logic [15:0] err_id;
    logic [15:0] rd_id;
    logic [31:0] rd_data;

    always #5 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (
        .clk(clk), .rst(rst), .list_start(list_start), .list_bytes(list_bytes),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_data(wr_data), .wr_mask(wr_mask),
        .err_flag(err_flag), .err_id(err_id), .rd_id(rd_id), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;
    int nlog  = 0;
    int base;
    logic [15:0] log_id   [0:63];
    logic [31:0] log_data [0:63];
    logic [3:0]  log_mask [0:63];

    always @(negedge clk) begin
        if (!rst && wr_valid && nlog < 64) begin
            log_id[nlog]   <= wr_id;
            log_data[nlog] <= wr_data;
            log_mask[nlog] <= wr_mask;
            nlog           <= nlog + 1;
        end
    end

    // {register, payload, mask, expected register contents afterwards}
    localparam logic [31:0] TV [0:5][0:3] = '{
        '{32'h010, 32'hAABBCCDD, 32'hF, 32'hAABBCCDD},
        '{32'h010, 32'h11223344, 32'h5, 32'hAA22CC44},
        '{32'h010, 32'h55667788, 32'hA, 32'h55227744},
        '{32'h010, 32'hFFFFFFFF, 32'h0, 32'h55227744},
        '{32'h2FF, 32'h12345678, 32'h1, 32'h00000078},
        '{32'h000, 32'hCAFEF00D, 32'hC, 32'hCAFE0000}
    };

    function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] m,
                                        input logic [7:0] cnt, input logic grp);
        return {grp, 3'b101, cnt, m, id};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_list(input int bytes);
        @(negedge clk);
        list_start = 1'b1;
        list_bytes = 16'(bytes);
        @(negedge clk);
        list_start = 1'b0;
    endtask

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_reg(input logic [15:0] id, output logic [31:0] v);
        rd_id = id;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; list_start = 1'b0; list_bytes = '0;
        in_valid = 1'b0; in_data = '0; rd_id = 16'h010;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 in_ready", in_ready, 0);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 err_flag", err_flag, 0);
        read_reg(16'h010, v);
        check("R1 regfile", v, 0);
        rst = 1'b0;

        // R2 R3 R6 table of single-packet lists
        for (int i = 0; i < 6; i++) begin
            base = nlog;
            start_list(8);
            send(TV[i][1]);
            send(hdr(TV[i][0][15:0], TV[i][3 - 1][3:0], 8'd0, 1'b0));
            settle();
            check("R2 write count", nlog - base, 1);
            check("R2 wr_id", log_id[base], TV[i][0]);
            check("R2 wr_data", log_data[base], TV[i][1]);
            check("R6 wr_mask", log_mask[base], TV[i][2]);
            read_reg(TV[i][0][15:0], v);
            check("R6 regfile merge", v, TV[i][3]);
        end
        check("R9 ready after list", in_ready, 0);

        // R4 grouped extras
        base = nlog;
        start_list(16);
        send(32'hA0000001);
        send(hdr(16'h100, 4'hF, 8'd2, 1'b1));
        send(32'hA0000002);
        send(32'hA0000003);
        settle();
        check("R4 count", nlog - base, 3);
        check("R4 id0", log_id[base], 32'h100);
        check("R4 id1", log_id[base+1], 32'h101);
        check("R4 id2", log_id[base+2], 32'h102);
        check("R4 data2", log_data[base+2], 32'hA0000003);

        // R5 repeated target
        base = nlog;
        start_list(16);
        send(32'h11111111);
        send(hdr(16'h200, 4'h3, 8'd2, 1'b0));
        send(32'h22222222);
        send(32'h33333333);
        settle();
        check("R5 count", nlog - base, 3);
        check("R5 id1", log_id[base+1], 32'h200);
        check("R5 id2", log_id[base+2], 32'h200);
        check("R6 mask on extra", log_mask[base+2], 32'h3);
        read_reg(16'h200, v);
        check("R6 lanes 0-1", v, 32'h00003333);

        // R7 filler word after odd-length packet
        base = nlog;
        start_list(24);
        send(32'h0000AAAA);
        send(hdr(16'h020, 4'hF, 8'd1, 1'b1));
        send(32'h0000BBBB);
        send(32'hDEADBEEF);
        send(32'h0000CCCC);
        send(hdr(16'h030, 4'hF, 8'd0, 1'b0));
        settle();
        check("R7 count", nlog - base, 3);
        check("R7 id", log_id[base+2], 32'h030);
        check("R7 data", log_data[base+2], 32'h0000CCCC);
        read_reg(16'h030, v);
        check("R7 regfile", v, 32'h0000CCCC);

        // R9 stop at length
        base = nlog;
        start_list(8);
        send(32'h00000001);
        send(hdr(16'h040, 4'hF, 8'd0, 1'b0));
        in_valid = 1'b1;
        in_data  = 32'h00000099;
        repeat (3) @(negedge clk);
        check("R9 ready low", in_ready, 0);
        check("R9 count", nlog - base, 1);
        in_valid = 1'b0;
        start_list(0);
        check("R9 zero length", in_ready, 0);

        // R8 out-of-range targets
        check("R8 err before", err_flag, 0);
        base = nlog;
        start_list(8);
        send(32'h00000099);
        send(hdr(16'h300, 4'hF, 8'd0, 1'b0));
        settle();
        check("R8 dropped", nlog - base, 0);
        check("R8 err_flag", err_flag, 1);
        check("R8 err_id", err_id, 32'h300);
        base = nlog;
        start_list(16);
        send(32'h00000077);
        send(hdr(16'h2FF, 4'hF, 8'd1, 1'b1));
        send(32'h00000088);
        settle();
        check("R8 cross count", nlog - base, 1);
        check("R8 cross id", log_id[base], 32'h2FF);
        check("R8 first id kept", err_id, 32'h300);
        read_reg(16'h2FF, v);
        check("R8 top entry", v, 32'h00000077);

        // R1 reset clears state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 err cleared", err_flag, 0);
        read_reg(16'h010, v);
        check("R1 regfile cleared", v, 0);

        finish_run();
    end

endmodule